// File: doc/BRIEF.md
# Burst Address Counter with Readback

This block is the address side of one memory port. It holds the internal address that drives the memory array and updates it on each rising clock edge from four active-low controls:
- a counter clear,
- an address load strobe,
- a count advance,
- an output enable.

It also takes a read/write select. The counter can load an external address, step through the array one location per clock, hold its value, or return to zero. Stepping past the last location wraps back to zero.

In one hold mode the current counter value is placed on the port's read-data bus instead of the word coming back from memory. This lets the controlling logic find out where an ongoing burst has reached. The port enable and the write strobe are registered next to the address, so every memory access uses the address that was produced on the same edge. The counter never depends on the port enable.

The depth, the data width and the bit offset of the readback field are parameters. The address width is derived from the depth.

Top module: `addr_burst_ctr`

## Requirements
- R1: While `rst` is high at a rising edge, the counter becomes 0, `mem_en` and `mem_we` become 0, and `dout` passes `mem_rdata`.
- R2: When `clr_n` is 0 at an edge, the counter becomes 0 whatever `ld_n` and `adv_n` are.
- R3: When `clr_n` is 1, `ld_n` is 0 and `adv_n` is 0 at an edge, the counter takes `ext_addr`.
- R4: When `clr_n` is 1, `ld_n` is 1 and `adv_n` is 0 at an edge, the counter rises by one.
- R5: Advancing from location DEPTH-1 gives 0 (DEPTH is 32768 by default).
- R6: When `clr_n`, `ld_n` and `adv_n` are all 1, the counter holds and `ext_addr` has no effect.
- R7: Readback mode is taken at an edge when `clr_n` is 1, `ld_n` is 0, `adv_n` is 1, `oe_n` is 0 and `rd` is 1. In that mode the counter holds. From that edge until the next one, `dout` carries the counter in bits RB_OFS upward (bits 3 to 17 by default), with every other bit 0.
- R8: With `clr_n` 1, `ld_n` 0 and `adv_n` 1 but `oe_n` 1 or `rd` 0, the counter holds and `dout` passes `mem_rdata`.
- R9: The counter behaves the same whatever `ce_n` is. `mem_en` shows the inverse of `ce_n` sampled at the last edge.
- R10: `mem_addr` is the counter value produced at the last edge. This includes a clear, so an access to location 0 can happen in the same cycle as the clear, with no dead cycle.
- R11: `mem_we` is 1 exactly when `ce_n` was 0 and `rd` was 0 at the last edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clr_n | input | 1 | Counter clear, active low, highest priority |
| ld_n | input | 1 | Address load strobe, active low |
| adv_n | input | 1 | Count advance, active low |
| oe_n | input | 1 | Output enable, active low, used to select readback |
| rd | input | 1 | 1 = read cycle, 0 = write cycle |
| ce_n | input | 1 | Port enable, active low; does not affect the counter |
| ext_addr | input | AW | External address to load |
| mem_rdata | input | DW | Word read back from the array |
| mem_addr | output | AW | Internal address to the array |
| mem_en | output | 1 | Registered access enable |
| mem_we | output | 1 | Registered write strobe |
| dout | output | DW | Read data or counter readback |

## Verification
The advance path is swept across all 32768 locations, starting from a clear and running through the wrap. This separates a correct wrap from a stuck top bit, and it also shows whether a skipped step occurs anywhere in the range.

A one-hot sweep loads each address bit on its own and reads it back. This exposes swapped or shifted bits, both in the load path and in where the readback field is placed.

A further set of cases applies load, hold and clear with every combination of the competing strobes, while `ext_addr` keeps changing. These show which of the strobes actually has priority.

The near-miss readback cases (output enable high, or a write cycle) confirm that the data path switches to readback only on the full condition.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
  typedef enum logic [2:0] {
    OP_HOLD = 3'd0,
    OP_CLR  = 3'd1,
    OP_LOAD = 3'd2,
    OP_INC  = 3'd3,
    OP_RDBK = 3'd4
  } ctr_op_e;
endpackage

// File: rtl/ctr_decode.sv
module ctr_decode
  import ctr_pkg::*;
(
  input  logic    clr_n,
  input  logic    ld_n,
  input  logic    adv_n,
  input  logic    oe_n,
  input  logic    rd,
  output ctr_op_e op
);
  always_comb begin
    if (!clr_n)                   op = OP_CLR;
    else if (!adv_n && !ld_n)     op = OP_LOAD;
    else if (!adv_n)              op = OP_INC;
    else if (!ld_n && !oe_n && rd) op = OP_RDBK;
    else                          op = OP_HOLD;
  end
endmodule

// File: rtl/ctr_core.sv
module ctr_core
  import ctr_pkg::*;
#(
  parameter int DEPTH = 32768,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  ctr_op_e       op,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] cnt
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else begin
      unique case (op)
        OP_CLR:  cnt <= '0;
        OP_LOAD: cnt <= ext_addr;
        OP_INC:  cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/rdbk_place.sv
module rdbk_place #(
  parameter int AW     = 15,
  parameter int DW     = 36,
  parameter int RB_OFS = 3
) (
  input  logic [AW-1:0] cnt,
  output logic [DW-1:0] word
);
  for (genvar i = 0; i < DW; i++) begin : g_bit
    if (i >= RB_OFS && i < RB_OFS + AW) begin : g_fld
      assign word[i] = cnt[i-RB_OFS];
    end else begin : g_zero
      assign word[i] = 1'b0;
    end
  end
endmodule

// File: rtl/addr_burst_ctr.sv
module addr_burst_ctr
  import ctr_pkg::*;
#(
  parameter int DEPTH  = 32768,
  parameter int DW     = 36,
  parameter int RB_OFS = 3,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_n,
  input  logic          ld_n,
  input  logic          adv_n,
  input  logic          oe_n,
  input  logic          rd,
  input  logic          ce_n,
  input  logic [AW-1:0] ext_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_en,
  output logic          mem_we,
  output logic [DW-1:0] dout
);
  ctr_op_e       op;
  logic [DW-1:0] rb_word;
  logic          rb_q;

  ctr_decode u_dec (
    .clr_n(clr_n), .ld_n(ld_n), .adv_n(adv_n),
    .oe_n(oe_n), .rd(rd), .op(op)
  );

  ctr_core #(.DEPTH(DEPTH), .AW(AW)) u_core (
    .clk(clk), .rst(rst), .op(op), .ext_addr(ext_addr), .cnt(mem_addr)
  );

  rdbk_place #(.AW(AW), .DW(DW), .RB_OFS(RB_OFS)) u_place (
    .cnt(mem_addr), .word(rb_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_en <= 1'b0;
      mem_we <= 1'b0;
      rb_q   <= 1'b0;
    end else begin
      mem_en <= !ce_n;
      mem_we <= !ce_n && !rd;
      rb_q   <= (op == OP_RDBK);
    end
  end

  assign dout = rb_q ? rb_word : mem_rdata;
endmodule

// File: rtl/addr_burst_ctr_chk.sv
module addr_burst_ctr_chk #(
  parameter int DEPTH  = 32768,
  parameter int DW     = 36,
  parameter int RB_OFS = 3,
  parameter int AW     = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst,
  input logic          clr_n,
  input logic          ld_n,
  input logic          adv_n,
  input logic          oe_n,
  input logic          rd,
  input logic          ce_n,
  input logic [AW-1:0] ext_addr,
  input logic [AW-1:0] mem_addr,
  input logic          mem_en,
  input logic          mem_we,
  input logic [DW-1:0] dout
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
    !clr_n |=> mem_addr == '0); // R2
  AST_LOAD_EXT: assert property (@(posedge clk) disable iff (rst)
    (clr_n && !ld_n && !adv_n) |=> mem_addr == $past(ext_addr)); // R3
  AST_ADV_WRAP: assert property (@(posedge clk) disable iff (rst)
    (clr_n && ld_n && !adv_n) |=>
      mem_addr == (($past(mem_addr) == LAST) ? '0 : $past(mem_addr) + 1'b1)); // R5
  AST_HOLD_CNT: assert property (@(posedge clk) disable iff (rst)
    (clr_n && adv_n) |=> $stable(mem_addr)); // R6
  AST_RDBK_FLD: assert property (@(posedge clk) disable iff (rst)
    (clr_n && !ld_n && adv_n && !oe_n && rd) |=> dout[RB_OFS +: AW] == mem_addr); // R7
  AST_EN_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> mem_en == !$past(ce_n)); // R9
  AST_WE_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> mem_we == (!$past(ce_n) && !$past(rd))); // R11
endmodule

bind addr_burst_ctr addr_burst_ctr_chk #(
  .DEPTH(DEPTH), .DW(DW), .RB_OFS(RB_OFS), .AW(AW)
) u_chk (
  .clk(clk), .rst(rst), .clr_n(clr_n), .ld_n(ld_n), .adv_n(adv_n),
  .oe_n(oe_n), .rd(rd), .ce_n(ce_n), .ext_addr(ext_addr),
  .mem_addr(mem_addr), .mem_en(mem_en), .mem_we(mem_we), .dout(dout)
);

// File: tb/sim_addr_burst_ctr.sv
`timescale 1ns/1ps
module sim_addr_burst_ctr;
  localparam int DEPTH = 32768;
  localparam int DW    = 36;
  localparam int OFS   = 3;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr_n = 1'b1, ld_n = 1'b1, adv_n = 1'b1, oe_n = 1'b1, rd = 1'b1, ce_n = 1'b1;
  logic [AW-1:0] ext_addr = '0;
  logic [DW-1:0] mem_rdata = '0;
  logic [AW-1:0] mem_addr;
  logic          mem_en, mem_we;
  logic [DW-1:0] dout;

  int total = 0;
  int fails = 0;
  int exp_cnt = 0;
  bit exp_rb = 0;

  always #2 clk = ~clk;

  addr_burst_ctr #(.DEPTH(DEPTH), .DW(DW), .RB_OFS(OFS)) u0 (
    .clk(clk), .rst(rst), .clr_n(clr_n), .ld_n(ld_n), .adv_n(adv_n),
    .oe_n(oe_n), .rd(rd), .ce_n(ce_n), .ext_addr(ext_addr),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_en(mem_en),
    .mem_we(mem_we), .dout(dout)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one edge with model update; outputs sampled 1 ns after the edge
  task automatic step(input logic c, input logic l, input logic a, input logic o,
                      input logic r, input logic e, input logic [AW-1:0] ea,
                      input logic [DW-1:0] rdat);
    clr_n = c; ld_n = l; adv_n = a; oe_n = o; rd = r; ce_n = e;
    ext_addr = ea; mem_rdata = rdat;
    @(posedge clk);
    #1;
    exp_rb = 0;
    if (!c) exp_cnt = 0;
    else if (!a && !l) exp_cnt = int'(ea);
    else if (!a) exp_cnt = (exp_cnt == DEPTH - 1) ? 0 : exp_cnt + 1;
    else if (!l && !o && r) exp_rb = 1;
  endtask

  function automatic longint exp_dout(input logic [DW-1:0] rdat);
    if (exp_rb) return longint'(exp_cnt) << OFS;
    return longint'(rdat);
  endfunction

  initial begin
    #(200000 * 4);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [DW-1:0] rd_pat;
    rd_pat = 36'h9_A5A5_A5A5;
    // R1 reset
    mem_rdata = rd_pat; ce_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 addr", mem_addr, 0);
    chk("R1 en", mem_en, 0);
    chk("R1 we", mem_we, 0);
    chk("R1 dout", dout, rd_pat);
    rst = 1'b0;

    // R3 load with write access, R10 R11
    step(1, 0, 0, 1, 0, 0, 15'h1234, rd_pat);
    chk("R3 load", mem_addr, exp_cnt);
    chk("R3 value", mem_addr, 15'h1234);
    chk("R10 en", mem_en, 1);
    chk("R11 we", mem_we, 1);

    // R4 advance while ext_addr changes (R6 ignored)
    for (int i = 0; i < 5; i++) begin
      step(1, 1, 0, 1, 1, 0, AW'(i * 777), rd_pat);
      chk("R4 adv", mem_addr, exp_cnt);
      chk("R11 read no we", mem_we, 0);
    end
    chk("R4 total", mem_addr, 15'h1239);

    // R6 hold with ext_addr changing
    for (int i = 0; i < 3; i++) begin
      step(1, 1, 1, 0, 1, 0, AW'(15'h7000 + i), rd_pat);
      chk("R6 hold", mem_addr, 15'h1239);
      chk("R6 dout", dout, rd_pat);
    end

    // R8 near-miss readback
    step(1, 0, 1, 1, 1, 0, 15'h0055, rd_pat);
    chk("R8 oe high addr", mem_addr, 15'h1239);
    chk("R8 oe high dout", dout, rd_pat);
    step(1, 0, 1, 0, 0, 0, 15'h0055, rd_pat);
    chk("R8 write addr", mem_addr, 15'h1239);
    chk("R8 write dout", dout, rd_pat);

    // R7 readback
    step(1, 0, 1, 0, 1, 0, 15'h0055, rd_pat);
    chk("R7 hold", mem_addr, 15'h1239);
    chk("R7 dout", dout, longint'(15'h1239) << OFS);

    // R2 clear beats load+advance, R10 write same cycle
    step(0, 0, 0, 1, 0, 0, 15'h4444, rd_pat);
    chk("R2 clr", mem_addr, 0);
    chk("R10 we at clr", mem_we, 1);
    step(0, 1, 0, 0, 1, 0, 15'h4444, rd_pat);
    chk("R2 clr adv", mem_addr, 0);
    chk("R2 dout", dout, rd_pat);

    // R9 disabled port still counts
    for (int i = 0; i < 4; i++) begin
      step(1, 1, 0, 1, 1, 1, '0, rd_pat);
      chk("R9 count", mem_addr, exp_cnt);
      chk("R9 en", mem_en, 0);
    end
    step(1, 0, 0, 1, 1, 1, 15'h0321, rd_pat);
    chk("R9 load", mem_addr, 15'h0321);

    // R5 wrap
    step(1, 0, 0, 1, 1, 0, AW'(DEPTH - 2), rd_pat);
    step(1, 1, 0, 1, 1, 0, '0, rd_pat);
    chk("R5 last", mem_addr, DEPTH - 1);
    step(1, 1, 0, 1, 1, 0, '0, rd_pat);
    chk("R5 wrap", mem_addr, 0);

    // R3 R7 one-hot sweep of load and readback field
    for (int b = 0; b < AW; b++) begin
      step(1, 0, 0, 1, 1, 0, AW'(1) << b, rd_pat);
      chk("R3 onehot", mem_addr, longint'(1) << b);
      step(1, 0, 1, 0, 1, 0, '1, ~rd_pat);
      chk("R7 onehot", dout, exp_dout(~rd_pat));
    end

    // R4 R5 exhaustive advance sweep across the whole array
    step(0, 1, 1, 1, 1, 0, '0, rd_pat);
    for (int k = 0; k < DEPTH + 2; k++) begin
      step(1, 1, 0, 1, 1, 0, AW'(k), rd_pat);
      chk("R4 sweep", mem_addr, exp_cnt);
    end
    chk("R5 sweep end", mem_addr, 2);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule